// File: doc/BRIEF.md
# MDIO Management Interface Master

This block runs single register accesses on a two-wire management bus toward an Ethernet PHY. The host presents a PHY address, a register address, a read/write selector and, for writes, a 16-bit data word. A one-cycle start pulse launches the access. While `busy` is high the block toggles the management clock and shifts the frame out on the data line. It releases the data line for the PHY's reply on reads. `done` pulses for one cycle when the access ends.

The management clock comes from the system clock. Each half period of it lasts `HALF_DIV` system clocks, so the integrator picks `HALF_DIV` to keep the bus at 2.5 MHz or below. The data line is split into a driven value, an output enable and a sampled input, to match a tri-state pad. On a read the block checks the turnaround bit to tell whether any PHY answered. If none did, it raises an error flag and returns zero data.

Top module: `mdio_master`

## Requirements
- R1: Every access starts with 32 bus clocks in which `mdio_oe` is 1 and `mdio_out` is 1 at each `mdc` rising edge.
- R2: After the preamble the block sends the start code 01, then the opcode (10 for read, 01 for write), then the 5-bit PHY address and the 5-bit register address, each field MSB first. These are bus bits 33 to 46, counted by `mdc` rising edge.
- R3: Each `mdc` half period lasts `HALF_DIV` system clocks. An access has exactly 64 rising edges. `mdio_out` and `mdio_oe` change only while `mdc` is low.
- R4: On a write, bits 47 and 48 are the turnaround pattern 1 then 0, and bits 49 to 64 carry `wr_data` MSB first. `mdio_oe` stays 1 at every rising edge.
- R5: On a read, `mdio_oe` is 1 at rising edges 1 to 46 and 0 at rising edges 47 to 64. The release and the return happen while `mdc` is low, with no extra edge. `mdio_oe` is back at 1 when `done` pulses.
- R6: On a read, the line is sampled in the low phase after the first turnaround clock. If that sample is 1, `rd_err` becomes 1 and `rd_data` becomes 0, whatever the line carried.
- R7: If that sample is 0, the 16 bits sampled in the low phases before rising edges 49 to 64 become `rd_data`, MSB first, and `rd_err` becomes 0. Both outputs keep their values until the next read completes.
- R8: A `start` pulse while `busy` is 1 is ignored. The frame on the bus and the number of `done` pulses do not change.
- R9: `busy` is high for exactly 129 × `HALF_DIV` cycles: 64 full bus clocks plus one final low phase. `done` is a single-cycle pulse in the cycle `busy` falls.
- R10: After reset, `mdc`=0, `mdio_out`=1, `mdio_oe`=1, `busy`=0, `done`=0, `rd_data`=0 and `rd_err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch an access (ignored while busy) |
| op_rd | input | 1 | 1 = read, 0 = write |
| phy_addr | input | 5 | Target PHY address |
| reg_addr | input | 5 | Target register address |
| wr_data | input | 16 | Data for a write |
| mdio_in | input | 1 | Sampled level of the bus data line |
| mdc | output | 1 | Management bus clock |
| mdio_out | output | 1 | Value driven onto the data line when enabled |
| mdio_oe | output | 1 | Output enable for the data line pad |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle end-of-access pulse |
| rd_data | output | 16 | Data returned by the last read |
| rd_err | output | 1 | Last read saw no PHY response |

## Verification
A slot counter that is off by one shows up as a shifted field. The PHY model would decode the wrong address, or catch a wrong turnaround pattern, within the same frame. The same fault also changes the rising-edge count and the busy duration, both of which are checked when the access ends. A wrong enable decode shows up as an enable value at edges 46 or 47, or as a contention cycle with the responder, during that read. A wrong capture window shows up as a bit-rotated or error-flagged `rd_data` when the access completes.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int ADDR_W    = 5;
    localparam int DATA_W    = 16;
    localparam int PRE_LEN   = 32;
    localparam int HDR_LEN   = 2 + 2 + 2 * ADDR_W;
    localparam int TA_LEN    = 2;
    localparam int FRAME_LEN = PRE_LEN + HDR_LEN + TA_LEN + DATA_W;
    // bus-clock slot indices, counted from 0
    localparam int TA_SLOT   = PRE_LEN + HDR_LEN;
    localparam int ERR_SLOT  = TA_SLOT + 1;
    localparam int DATA_SLOT = TA_SLOT + TA_LEN;
    localparam int END_SLOT  = FRAME_LEN;
    localparam int SLOT_W    = $clog2(FRAME_LEN + 1);

    typedef enum logic [1:0] {
        OPC_WRITE = 2'b01,
        OPC_READ  = 2'b10
    } opcode_e;

    localparam logic [1:0] SOF_CODE = 2'b01;
    localparam logic [1:0] WR_TURN  = 2'b10;

    typedef struct packed {
        logic              rd;
        logic [ADDR_W-1:0] phy;
        logic [ADDR_W-1:0] regad;
        logic [DATA_W-1:0] wdata;
    } mdio_req_t;

    function automatic logic [FRAME_LEN-1:0] build_frame(mdio_req_t q);
        opcode_e opc;
        opc = q.rd ? OPC_READ : OPC_WRITE;
        return {{PRE_LEN{1'b1}}, SOF_CODE, logic'(opc[1]), logic'(opc[0]),
                q.phy, q.regad, WR_TURN, q.wdata};
    endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int HALF_DIV = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CNT_W = $clog2(HALF_DIV + 1);

    logic [CNT_W-1:0] cnt;

    assign tick = run && (cnt == CNT_W'(HALF_DIV - 1));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  mdio_req_t         req,
    input  logic              tick,
    input  logic              mdio_in,
    output logic              busy,
    output logic              mdc,
    output logic              mdio_out,
    output logic              mdio_oe,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_err
);
    logic                 hi;
    logic [SLOT_W-1:0]    slot;
    logic [FRAME_LEN-1:0] shreg;
    logic                 is_rd;
    logic                 err_q;
    logic [DATA_W-1:0]    cap;
    logic                 in_reply;

    assign in_reply = (slot >= SLOT_W'(TA_SLOT)) && (slot < SLOT_W'(END_SLOT));
    assign mdc      = busy && hi;
    assign mdio_out = busy ? shreg[FRAME_LEN-1] : 1'b1;
    assign mdio_oe  = !(busy && is_rd && in_reply);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            hi      <= 1'b0;
            slot    <= '0;
            shreg   <= '1;
            is_rd   <= 1'b0;
            err_q   <= 1'b0;
            cap     <= '0;
            done    <= 1'b0;
            rd_data <= '0;
            rd_err  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy  <= 1'b1;
                    hi    <= 1'b0;
                    slot  <= '0;
                    shreg <= build_frame(req);
                    is_rd <= req.rd;
                    err_q <= 1'b0;
                    cap   <= '0;
                end
            end else if (tick) begin
                if (!hi) begin
                    if (slot == SLOT_W'(END_SLOT)) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                        if (is_rd) begin
                            rd_err  <= err_q;
                            rd_data <= err_q ? '0 : cap;
                        end
                    end else begin
                        hi <= 1'b1;
                        if (is_rd && slot == SLOT_W'(ERR_SLOT)) begin
                            err_q <= mdio_in;
                        end
                        if (is_rd && slot >= SLOT_W'(DATA_SLOT)) begin
                            cap <= {cap[DATA_W-2:0], mdio_in};
                        end
                    end
                end else begin
                    hi    <= 1'b0;
                    slot  <= slot + SLOT_W'(1);
                    shreg <= {shreg[FRAME_LEN-2:0], 1'b1};
                end
            end
        end
    end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int HALF_DIV = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              op_rd,
    input  logic [ADDR_W-1:0] phy_addr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              mdio_in,
    output logic              mdc,
    output logic              mdio_out,
    output logic              mdio_oe,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_err
);
    mdio_req_t req;
    logic      tick;

    assign req = '{rd: op_rd, phy: phy_addr, regad: reg_addr, wdata: wr_data};

    mdio_clkgen #(.HALF_DIV(HALF_DIV)) u_clkgen (
        .clk  (clk),
        .rst  (rst),
        .run  (busy),
        .tick (tick)
    );

    mdio_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .req      (req),
        .tick     (tick),
        .mdio_in  (mdio_in),
        .busy     (busy),
        .mdc      (mdc),
        .mdio_out (mdio_out),
        .mdio_oe  (mdio_oe),
        .done     (done),
        .rd_data  (rd_data),
        .rd_err   (rd_err)
    );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
    input logic        clk,
    input logic        rst,
    input logic        mdc,
    input logic        mdio_out,
    input logic        mdio_oe,
    input logic        busy,
    input logic        done,
    input logic [15:0] rd_data,
    input logic        rd_err
);
    // R3
    line_hold_chk: assert property (@(posedge clk) disable iff (rst)
        mdc |-> $stable(mdio_out) && $stable(mdio_oe));

    // R3
    idle_bus_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mdc && mdio_out && mdio_oe);

    // R5
    release_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
        !mdio_oe |-> busy);

    // R6
    err_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rd_err |-> rd_data == 16'h0000);

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    done_at_end_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy && $past(busy) && mdio_oe);
endmodule

bind mdio_master mdio_master_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .mdc      (mdc),
    .mdio_out (mdio_out),
    .mdio_oe  (mdio_oe),
    .busy     (busy),
    .done     (done),
    .rd_data  (rd_data),
    .rd_err   (rd_err)
);

// File: tb/mdio_master_test.sv
module mdio_master_test;
    localparam int HD = 2;
    localparam logic [4:0] PHY_ADDR = 5'd5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        op_rd = 1'b0;
    logic [4:0]  phy_addr = '0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] wr_data = '0;
    logic        mdio_in;
    logic        mdc, mdio_out, mdio_oe, busy, done, rd_err;
    logic [15:0] rd_data;
    logic        phy_en = 1'b0;
    logic        phy_val = 1'b1;

    always #2.5 clk = ~clk;

    assign mdio_in = mdio_oe ? mdio_out : (phy_en ? phy_val : 1'b1);

    mdio_master #(.HALF_DIV(HD)) uut (
        .clk(clk), .rst(rst), .start(start), .op_rd(op_rd),
        .phy_addr(phy_addr), .reg_addr(reg_addr), .wr_data(wr_data),
        .mdio_in(mdio_in), .mdc(mdc), .mdio_out(mdio_out), .mdio_oe(mdio_oe),
        .busy(busy), .done(done), .rd_data(rd_data), .rd_err(rd_err)
    );

    int checks = 0;
    int fails = 0;
    int edge_n = 0;
    int contention = 0;
    logic [15:0] phy_mem [32];
    logic [15:0] exp_mem [32];
    logic out_bits [1:64];
    logic oe_bits [1:64];
    logic [4:0] live_reg;

    function automatic logic [15:0] field(int e0, int n);
        logic [15:0] v = '0;
        for (int i = 0; i < n; i++) v = {v[14:0], out_bits[e0 + i]};
        return v;
    endfunction

    // simple PHY responder, indexed by bus rising edge (1-based)
    always @(posedge mdc) begin
        edge_n = edge_n + 1;
        if (edge_n <= 64) begin
            out_bits[edge_n] = mdio_out;
            oe_bits[edge_n]  = mdio_oe;
        end
        if (edge_n == 47) begin
            live_reg = field(42, 5);
            if (out_bits[35] && !out_bits[36] && field(37, 5) == 16'(PHY_ADDR)) begin
                phy_en  = 1'b1;
                phy_val = 1'b0;
            end
        end else if (edge_n >= 48 && edge_n <= 63 && phy_en) begin
            phy_val = phy_mem[live_reg][63 - edge_n];
        end else if (edge_n == 64) begin
            phy_en = 1'b0;
        end
    end

    always @(negedge clk) if (phy_en && mdio_oe) contention++;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_txn(input bit rd, input logic [4:0] p, input logic [4:0] r,
                           input logic [15:0] d, input bit inject);
        int cyc = 0;
        int ndone = 0;
        int hi = 0;
        bit ok;
        @(negedge clk);
        op_rd = rd; phy_addr = p; reg_addr = r; wr_data = d;
        edge_n = 0; contention = 0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R9 busy after start", 32'(busy), 32'd1);
        while (busy) begin
            cyc++;
            if (done) ndone++;
            if (mdc) hi++;
            if (inject) begin
                start = (cyc == 40);
                op_rd = !rd; phy_addr = ~p; reg_addr = ~r; wr_data = ~d;
            end
            @(negedge clk);
        end
        start = 1'b0;
        check(done == 1'b1, "R9 done at busy fall", 32'(done), 32'd1);
        check(ndone == 0, "R9 no done while busy", 32'(ndone), 32'd0);
        check(cyc == 129 * HD, "R9 busy length", 32'(cyc), 32'(129 * HD));
        check(edge_n == 64, "R3 rising edge count", 32'(edge_n), 32'd64);
        check(hi == 64 * HD, "R3 mdc high time", 32'(hi), 32'(64 * HD));
        ok = 1'b1;
        for (int e = 1; e <= 32; e++) if (!out_bits[e] || !oe_bits[e]) ok = 1'b0;
        check(ok, "R1 preamble", 32'(ok), 32'd1);
        check(field(33, 2) == 16'h1, "R2 start code", 32'(field(33, 2)), 32'h1);
        check(field(35, 2) == (rd ? 16'h2 : 16'h1), "R2 opcode", 32'(field(35, 2)), rd ? 32'h2 : 32'h1);
        check(field(37, 5) == 16'(p), "R2 phy address", 32'(field(37, 5)), 32'(p));
        check(field(42, 5) == 16'(r), "R2 register address", 32'(field(42, 5)), 32'(r));
        if (!rd) begin
            ok = 1'b1;
            for (int e = 1; e <= 64; e++) if (!oe_bits[e]) ok = 1'b0;
            check(ok, "R4 enable held on write", 32'(ok), 32'd1);
            check(field(47, 2) == 16'h2, "R4 turnaround", 32'(field(47, 2)), 32'h2);
            check(field(49, 16) == d, "R4 write data", 32'(field(49, 16)), 32'(d));
            if (p == PHY_ADDR) begin
                phy_mem[r] = field(49, 16);
                exp_mem[r] = d;
            end
        end else begin
            ok = 1'b1;
            for (int e = 1; e <= 46; e++) if (!oe_bits[e]) ok = 1'b0;
            for (int e = 47; e <= 64; e++) if (oe_bits[e]) ok = 1'b0;
            check(ok, "R5 enable window", 32'(ok), 32'd1);
            check(contention == 0, "R5 no contention", 32'(contention), 32'd0);
            if (p == PHY_ADDR) begin
                check(rd_err == 1'b0, "R7 no error", 32'(rd_err), 32'd0);
                check(rd_data == exp_mem[r], "R7 read data", 32'(rd_data), 32'(exp_mem[r]));
            end else begin
                check(rd_err == 1'b1, "R6 error flag", 32'(rd_err), 32'd1);
                check(rd_data == 16'h0, "R6 zero data", 32'(rd_data), 32'h0);
            end
        end
        if (inject) check(field(37, 5) == 16'(p) && field(42, 5) == 16'(r),
                          "R8 start ignored while busy", 32'(field(37, 10)), 32'({p, r}));
        @(negedge clk);
        check(done == 1'b0, "R9 done one cycle", 32'(done), 32'd0);
        check(mdio_oe && !mdc && !busy, "R5 bus retaken when idle", 32'({mdio_oe, mdc, busy}), 32'h4);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) begin
            phy_mem[i] = '0;
            exp_mem[i] = '0;
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check(!mdc && mdio_out && mdio_oe && !busy && !done, "R10 reset control outputs",
              32'({mdc, mdio_out, mdio_oe, busy, done}), 32'h0C);
        check(rd_data == 16'h0 && !rd_err, "R10 reset read outputs", 32'({rd_err, rd_data}), 32'h0);
        // writes to every PHY address
        for (int p = 0; p < 32; p++)
            run_txn(1'b0, 5'(p), 5'((p * 7) % 32), 16'hA5C3 ^ 16'(p * 16'h1111), 1'b0);
        // reads from every PHY address: one answers, the rest report errors
        for (int p = 0; p < 32; p++)
            run_txn(1'b1, 5'(p), 5'((p * 7) % 32), 16'h0, 1'b0);
        // fill the responder and read it all back
        for (int r = 0; r < 32; r++)
            run_txn(1'b0, PHY_ADDR, 5'(r), (r == 0) ? 16'hFFFF : (r == 1) ? 16'h8001 : 16'({r[7:0], ~r[7:0]}), 1'b0);
        for (int r = 0; r < 32; r++)
            run_txn(1'b1, PHY_ADDR, 5'(r), 16'h0, 1'b0);
        // R8 start pulses during an access
        run_txn(1'b0, PHY_ADDR, 5'd3, 16'h1234, 1'b1);
        run_txn(1'b1, PHY_ADDR, 5'd3, 16'h0, 1'b1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule